// File: doc/BRIEF.md
# Program Flow Sequencer with Hardware Stacks

This block owns the program counter of a DSP core with 16-bit instruction addresses. The decode stage hands it one operation per cycle, along with the condition outcome, the instruction length in words, and the operands the operation needs: a branch target, a count and an end address. The block then chooses the next address. It covers plain sequential flow, jumps, subroutine calls and returns, conditional skipping, counted block loops without overhead, and repetition of a single instruction.

Return addresses live on a 4-entry stack that calls and loops share. Loop counts and loop end addresses each live on their own 4-entry stack, and those two move together. When a loop stage steps sequentially onto the end address held on top of the end-address stack, the sequencer either jumps back to the loop start or retires the loop. A stack fault leaves the PC where it was and raises a one-cycle error-interrupt pulse. A trap instruction raises a one-cycle trap-interrupt pulse. Vectoring to the handler is left to the interrupt unit.

Top module: `flow_seq`

## Requirements
- R1: After reset the PC is 0, the repeat count is 0, both interrupt outputs are low and all three stacks are empty.
- R2: An accepted operation takes effect on the clock edge that samples `step`. Sequential (op 0) and wait-released steps advance the PC by `len`. A jump (op 1), call (op 2) or return (op 3) with `cond` low also advances the PC by `len`, pushes nothing and pops nothing.
- R3: A taken jump loads `target` into the PC. A taken call pushes PC+`len` onto the return stack and loads `target`.
- R4: The return stack holds 4 entries. A taken call when it is full leaves the PC unchanged and pulses `err_irq` high for one cycle, starting the cycle after the step.
- R5: A taken return loads the PC from the top of the return stack and pops it. When the stack is empty, the PC is unchanged and `err_irq` pulses.
- R6: A conditional execute (op 4) advances the PC by 1 when `cond` is high and by 2 when it is low.
- R7: A loop (op 5) with a nonzero `count` pushes PC+2 onto the return stack, `count` onto the count stack and `end_addr` onto the end stack, then sets the PC to PC+2. If any of the three stacks is full, nothing is pushed, the PC is unchanged and `err_irq` pulses.
- R8: A loop whose `count` is 0 sets the PC to `end_addr`+1 and pushes nothing.
- R9: A sequential step taken while the PC equals the top end address does one of two things. If the top count is above 1, the top count is decremented and the PC is loaded from the top of the return stack. If the top count is 1, all three stacks are popped and the PC advances by `len`.
- R10: A repeat (op 6) with a nonzero `count` loads `rep_cnt` and advances the PC by 1. While `rep_cnt` is above 1, each step holds the PC and decrements `rep_cnt`. When `rep_cnt` is 1, the step executes its own operation normally and `rep_cnt` becomes 0. A zero count advances the PC by 2.
- R11: A trap (op 7) pulses `trap_irq` for one cycle, starting the cycle after the step, and advances the PC by `len`.
- R12: A wait (op 8) holds the PC while `wake` is low and advances it by `len` when `wake` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step | input | 1 | An operation is presented this cycle |
| op | input | 4 | Operation code (see requirements) |
| cond | input | 1 | Condition outcome for the operation |
| len | input | 2 | Instruction length in 16-bit words |
| target | input | 16 | Jump or call destination |
| count | input | 16 | Loop or repeat count |
| end_addr | input | 16 | Address of the last loop instruction |
| wake | input | 1 | Releases a wait |
| pc | output | 16 | Current program counter |
| rep_cnt | output | 16 | Remaining repeat count |
| err_irq | output | 1 | Stack-fault interrupt pulse |
| trap_irq | output | 1 | Trap interrupt pulse |

## Verification
Loop-end detection and the last pass of a single-instruction repeat can land in the same cycle. This happens when the repeated instruction is itself the final instruction of a block loop. The bench builds exactly that case: a two-pass loop whose end address is the instruction that follows a repeat. It then checks three things. The PC must stay put while the repeat count is above 1. On the final repeat step, the PC must jump back to the loop start, or fall through on the last pass. The repeat count must reach zero in that same cycle.

// File: rtl/flow_pkg.sv
package flow_pkg;
  typedef enum logic [3:0] {
    OP_SEQ  = 4'd0,
    OP_JMP  = 4'd1,
    OP_CALL = 4'd2,
    OP_RET  = 4'd3,
    OP_EXEC = 4'd4,
    OP_LOOP = 4'd5,
    OP_REP  = 4'd6,
    OP_TRAP = 4'd7,
    OP_WAIT = 4'd8
  } flow_op_e;

  // next sequential address: pc plus a word count
  function automatic logic [15:0] adv(input logic [15:0] pc, input logic [1:0] n);
    return pc + {14'd0, n};
  endfunction
endpackage

// File: rtl/flow_lifo.sv
module flow_lifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic         set_top,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         full,
  output logic         empty
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] ptr;
  logic [IW-1:0] wr_idx, top_idx;

  assign wr_idx  = ptr[IW-1:0];
  assign top_idx = wr_idx - IW'(1);
  assign top     = mem[top_idx];
  assign full    = (ptr == PW'(DEPTH));
  assign empty   = (ptr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (push) ptr <= ptr + PW'(1);
    else if (pop)  ptr <= ptr - PW'(1);
  end

  always_ff @(posedge clk) begin
    if (push)                   mem[wr_idx]  <= din;
    else if (set_top && !empty) mem[top_idx] <= din;
  end

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
  p_single_move_r7: assert property (@(posedge clk) disable iff (!rst_n) !(push && pop));
endmodule

// File: rtl/flow_ctl.sv
module flow_ctl
  import flow_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          step,
  input  logic [3:0]    op,
  input  logic          cond,
  input  logic [1:0]    len,
  input  logic [AW-1:0] target,
  input  logic [CW-1:0] count,
  input  logic [AW-1:0] end_addr,
  input  logic          wake,
  input  logic [AW-1:0] pc,
  input  logic [CW-1:0] rep,
  input  logic [AW-1:0] ret_top,
  input  logic          ret_full,
  input  logic          ret_empty,
  input  logic [CW-1:0] cnt_top,
  input  logic          cnt_full,
  input  logic          cnt_empty,
  input  logic [AW-1:0] end_top,
  input  logic          end_full,
  input  logic          end_empty,
  output logic [AW-1:0] pc_nxt,
  output logic [CW-1:0] rep_nxt,
  output logic          ret_push,
  output logic          ret_pop,
  output logic [AW-1:0] ret_din,
  output logic          loop_push,
  output logic          loop_pop,
  output logic          cnt_dec,
  output logic [CW-1:0] cnt_din,
  output logic          err_evt,
  output logic          trap_evt,
  output logic          at_end
);
  logic [AW-1:0] seq_pc;
  assign seq_pc = adv(pc, len);
  assign at_end = !cnt_empty && !end_empty && (pc == end_top);

  always_comb begin
    pc_nxt    = pc;
    rep_nxt   = rep;
    ret_push  = 1'b0;
    ret_pop   = 1'b0;
    ret_din   = seq_pc;
    loop_push = 1'b0;
    loop_pop  = 1'b0;
    cnt_dec   = 1'b0;
    cnt_din   = count;
    err_evt   = 1'b0;
    trap_evt  = 1'b0;
    if (step) begin
      if (rep > CW'(1)) begin
        rep_nxt = rep - CW'(1);
      end else begin
        rep_nxt = '0;
        case (flow_op_e'(op))
          OP_SEQ: begin
            if (at_end && cnt_top > CW'(1)) begin
              cnt_dec = 1'b1;
              cnt_din = cnt_top - CW'(1);
              pc_nxt  = ret_top;
            end else begin
              if (at_end) begin
                loop_pop = 1'b1;
                ret_pop  = 1'b1;
              end
              pc_nxt = seq_pc;
            end
          end
          OP_JMP:  pc_nxt = cond ? target : seq_pc;
          OP_CALL: begin
            if (!cond)        pc_nxt = seq_pc;
            else if (ret_full) err_evt = 1'b1;
            else begin
              ret_push = 1'b1;
              pc_nxt   = target;
            end
          end
          OP_RET: begin
            if (!cond)          pc_nxt = seq_pc;
            else if (ret_empty) err_evt = 1'b1;
            else begin
              ret_pop = 1'b1;
              pc_nxt  = ret_top;
            end
          end
          OP_EXEC: pc_nxt = cond ? adv(pc, 2'd1) : adv(pc, 2'd2);
          OP_LOOP: begin
            if (count == '0)                           pc_nxt = end_addr + AW'(1);
            else if (ret_full || cnt_full || end_full) err_evt = 1'b1;
            else begin
              ret_push  = 1'b1;
              ret_din   = adv(pc, 2'd2);
              loop_push = 1'b1;
              pc_nxt    = adv(pc, 2'd2);
            end
          end
          OP_REP: begin
            if (count == '0) pc_nxt = adv(pc, 2'd2);
            else begin
              rep_nxt = count;
              pc_nxt  = adv(pc, 2'd1);
            end
          end
          OP_TRAP: begin
            trap_evt = 1'b1;
            pc_nxt   = seq_pc;
          end
          OP_WAIT: pc_nxt = wake ? seq_pc : pc;
          default: pc_nxt = seq_pc;
        endcase
      end
    end
  end
endmodule

// File: rtl/flow_seq.sv
module flow_seq
  import flow_pkg::*;
#(
  parameter int AW    = 16,
  parameter int CW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [3:0]    op,
  input  logic          cond,
  input  logic [1:0]    len,
  input  logic [AW-1:0] target,
  input  logic [CW-1:0] count,
  input  logic [AW-1:0] end_addr,
  input  logic          wake,
  output logic [AW-1:0] pc,
  output logic [CW-1:0] rep_cnt,
  output logic          err_irq,
  output logic          trap_irq
);
  logic [AW-1:0] pc_q, pc_nxt, ret_top, ret_din, end_top;
  logic [CW-1:0] rep_q, rep_nxt, cnt_top, cnt_din;
  logic ret_full, ret_empty, cnt_full, cnt_empty, end_full, end_empty;
  logic ret_push, ret_pop, loop_push, loop_pop, cnt_dec;
  logic err_evt, trap_evt, at_end;
  logic err_q, trap_q;

  flow_ctl #(.AW(AW), .CW(CW)) u_ctl (
    .step(step), .op(op), .cond(cond), .len(len), .target(target),
    .count(count), .end_addr(end_addr), .wake(wake), .pc(pc_q), .rep(rep_q),
    .ret_top(ret_top), .ret_full(ret_full), .ret_empty(ret_empty),
    .cnt_top(cnt_top), .cnt_full(cnt_full), .cnt_empty(cnt_empty),
    .end_top(end_top), .end_full(end_full), .end_empty(end_empty),
    .pc_nxt(pc_nxt), .rep_nxt(rep_nxt), .ret_push(ret_push), .ret_pop(ret_pop),
    .ret_din(ret_din), .loop_push(loop_push), .loop_pop(loop_pop),
    .cnt_dec(cnt_dec), .cnt_din(cnt_din), .err_evt(err_evt),
    .trap_evt(trap_evt), .at_end(at_end)
  );

  flow_lifo #(.W(AW), .DEPTH(DEPTH)) u_ret (
    .clk(clk), .rst_n(rst_n), .push(ret_push), .pop(ret_pop), .set_top(1'b0),
    .din(ret_din), .top(ret_top), .full(ret_full), .empty(ret_empty)
  );

  flow_lifo #(.W(CW), .DEPTH(DEPTH)) u_cnt (
    .clk(clk), .rst_n(rst_n), .push(loop_push), .pop(loop_pop), .set_top(cnt_dec),
    .din(cnt_din), .top(cnt_top), .full(cnt_full), .empty(cnt_empty)
  );

  flow_lifo #(.W(AW), .DEPTH(DEPTH)) u_end (
    .clk(clk), .rst_n(rst_n), .push(loop_push), .pop(loop_pop), .set_top(1'b0),
    .din(end_addr), .top(end_top), .full(end_full), .empty(end_empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      rep_q  <= '0;
      err_q  <= 1'b0;
      trap_q <= 1'b0;
    end else begin
      pc_q   <= pc_nxt;
      rep_q  <= rep_nxt;
      err_q  <= err_evt;
      trap_q <= trap_evt;
    end
  end

  assign pc       = pc_q;
  assign rep_cnt  = rep_q;
  assign err_irq  = err_q;
  assign trap_irq = trap_q;

  p_fault_holds_pc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> (pc_q == $past(pc_q)) && err_irq);
  p_rep_holds_pc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (step && rep_q > CW'(1)) |=> $stable(pc_q) && (rep_q == $past(rep_q) - CW'(1)));
  p_trap_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    trap_evt |=> trap_irq);
  p_loop_stacks_agree_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_empty == end_empty) && (cnt_full == end_full));
  p_loop_back_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_dec |=> pc_q == $past(ret_top));
  p_no_idle_move_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pc_q));
endmodule

// File: tb/flow_seq_tb.sv
module flow_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step = 1'b0;
  logic [3:0]  op = 4'd0;
  logic        cond = 1'b0;
  logic [1:0]  len = 2'd1;
  logic [15:0] target = 16'd0;
  logic [15:0] count = 16'd0;
  logic [15:0] end_addr = 16'd0;
  logic        wake = 1'b0;
  logic [15:0] pc, rep_cnt;
  logic        err_irq, trap_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  flow_seq u_dut (
    .clk(clk), .rst_n(rst_n), .step(step), .op(op), .cond(cond), .len(len),
    .target(target), .count(count), .end_addr(end_addr), .wake(wake),
    .pc(pc), .rep_cnt(rep_cnt), .err_irq(err_irq), .trap_irq(trap_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] o, input logic c, input logic [1:0] n,
                       input logic [15:0] t, input logic [15:0] cn, input logic [15:0] ea,
                       input logic w);
    op = o; cond = c; len = n; target = t; count = cn; end_addr = ea; wake = w;
    step = 1'b1;
    @(posedge clk);
    @(negedge clk);
    step = 1'b0;
  endtask

  task automatic seq1();
    issue(4'd0, 1'b0, 2'd1, 16'd0, 16'd0, 16'd0, 1'b0);
  endtask

  task automatic t_reset();
    check("R1 pc", pc, 0);
    check("R1 rep_cnt", rep_cnt, 0);
    check("R1 irqs", {err_irq, trap_irq}, 0);
    issue(4'd3, 1'b1, 2'd1, 16'd0, 16'd0, 16'd0, 1'b0);
    check("R1 return stack empty", err_irq, 1);
    check("R1 pc kept", pc, 0);
  endtask

  task automatic t_untaken();
    issue(4'd1, 1'b0, 2'd2, 16'h0900, 16'd0, 16'd0, 1'b0);
    check("R2 untaken jump", pc, 16'h0002);
    issue(4'd2, 1'b0, 2'd1, 16'h0900, 16'd0, 16'd0, 1'b0);
    check("R2 untaken call", pc, 16'h0003);
    issue(4'd3, 1'b0, 2'd1, 16'd0, 16'd0, 16'd0, 1'b0);
    check("R2 untaken return", pc, 16'h0004);
    check("R2 no fault", err_irq, 0);
  endtask

  task automatic t_branch();
    issue(4'd1, 1'b1, 2'd2, 16'h0100, 16'd0, 16'd0, 1'b0);
    check("R3 jump", pc, 16'h0100);
    issue(4'd2, 1'b1, 2'd2, 16'h0200, 16'd0, 16'd0, 1'b0);
    check("R3 call", pc, 16'h0200);
    issue(4'd3, 1'b1, 2'd1, 16'd0, 16'd0, 16'd0, 1'b0);
    check("R5 return", pc, 16'h0102);
    check("R5 no fault", err_irq, 0);
    issue(4'd3, 1'b1, 2'd1, 16'd0, 16'd0, 16'd0, 1'b0);
    check("R5 empty return fault", err_irq, 1);
    check("R5 pc kept", pc, 16'h0102);
    seq1();
    check("R5 fault one cycle", err_irq, 0);
  endtask

  task automatic t_overflow();
    // pc 0x103 -> pushes 0x104, then three pushes of 0x301
    for (int i = 0; i < 4; i++) issue(4'd2, 1'b1, 2'd1, 16'h0300, 16'd0, 16'd0, 1'b0);
    check("R3 nested call", pc, 16'h0300);
    issue(4'd5, 1'b1, 2'd2, 16'd0, 16'd2, 16'h0310, 1'b0);
    check("R7 loop on full fault", err_irq, 1);
    check("R7 pc kept", pc, 16'h0300);
    issue(4'd2, 1'b1, 2'd1, 16'h0700, 16'd0, 16'd0, 1'b0);
    check("R4 overflow fault", err_irq, 1);
    check("R4 pc kept", pc, 16'h0300);
    for (int i = 0; i < 3; i++) issue(4'd3, 1'b1, 2'd1, 16'd0, 16'd0, 16'd0, 1'b0);
    check("R5 inner return", pc, 16'h0301);
    issue(4'd3, 1'b1, 2'd1, 16'd0, 16'd0, 16'd0, 1'b0);
    check("R5 outer return", pc, 16'h0104);
    check("R4 no fault", err_irq, 0);
  endtask

  task automatic t_exec();
    issue(4'd4, 1'b1, 2'd1, 16'd0, 16'd0, 16'd0, 1'b0);
    check("R6 exec true", pc, 16'h0105);
    issue(4'd4, 1'b0, 2'd1, 16'd0, 16'd0, 16'd0, 1'b0);
    check("R6 exec false", pc, 16'h0107);
  endtask

  task automatic t_loop();
    issue(4'd1, 1'b1, 2'd1, 16'h0400, 16'd0, 16'd0, 1'b0);
    issue(4'd5, 1'b1, 2'd2, 16'd0, 16'd3, 16'h0404, 1'b0);
    check("R7 loop entry", pc, 16'h0402);
    for (int pass = 0; pass < 2; pass++) begin
      seq1(); seq1();
      check("R9 at end", pc, 16'h0404);
      seq1();
      check("R9 loop back", pc, 16'h0402);
    end
    seq1(); seq1(); seq1();
    check("R9 loop exit", pc, 16'h0405);
    seq1();
    check("R9 stacks popped", pc, 16'h0406);
    issue(4'd3, 1'b1, 2'd1, 16'd0, 16'd0, 16'd0, 1'b0);
    check("R9 return stack popped", err_irq, 1);
    issue(4'd5, 1'b1, 2'd2, 16'd0, 16'd0, 16'h0500, 1'b0);
    check("R8 zero loop skip", pc, 16'h0501);
    seq1();
    check("R8 nothing pushed", pc, 16'h0502);
  endtask

  task automatic t_repeat();
    issue(4'd6, 1'b1, 2'd1, 16'd0, 16'd3, 16'd0, 1'b0);
    check("R10 rep entry pc", pc, 16'h0503);
    check("R10 rep loaded", rep_cnt, 3);
    seq1();
    check("R10 hold pc", pc, 16'h0503);
    check("R10 rep dec", rep_cnt, 2);
    issue(4'd1, 1'b1, 2'd1, 16'h0F00, 16'd0, 16'd0, 1'b0);
    check("R10 hold ignores op", pc, 16'h0503);
    issue(4'd4, 1'b1, 2'd1, 16'd0, 16'd0, 16'd0, 1'b0);
    check("R10 last executes", pc, 16'h0504);
    check("R10 rep cleared", rep_cnt, 0);
    issue(4'd6, 1'b1, 2'd1, 16'd0, 16'd0, 16'd0, 1'b0);
    check("R10 zero rep skip", pc, 16'h0506);
  endtask

  task automatic t_overlap();
    issue(4'd1, 1'b1, 2'd1, 16'h0600, 16'd0, 16'd0, 1'b0);
    issue(4'd5, 1'b1, 2'd2, 16'd0, 16'd2, 16'h0603, 1'b0);
    issue(4'd6, 1'b1, 2'd1, 16'd0, 16'd2, 16'd0, 1'b0);
    seq1();
    check("R10 repeat at end hold", pc, 16'h0603);
    seq1();
    check("R9 R10 last repeat loops back", pc, 16'h0602);
    check("R10 rep zero on overlap", rep_cnt, 0);
    issue(4'd6, 1'b1, 2'd1, 16'd0, 16'd2, 16'd0, 1'b0);
    seq1(); seq1();
    check("R9 R10 last repeat exits", pc, 16'h0604);
  endtask

  task automatic t_trap_wait();
    issue(4'd7, 1'b0, 2'd1, 16'd0, 16'd0, 16'd0, 1'b0);
    check("R11 trap pulse", trap_irq, 1);
    check("R11 trap pc", pc, 16'h0605);
    issue(4'd8, 1'b0, 2'd1, 16'd0, 16'd0, 16'd0, 1'b0);
    check("R11 trap one cycle", trap_irq, 0);
    check("R12 wait hold", pc, 16'h0605);
    issue(4'd8, 1'b0, 2'd1, 16'd0, 16'd0, 16'd0, 1'b0);
    check("R12 wait hold again", pc, 16'h0605);
    issue(4'd8, 1'b0, 2'd1, 16'd0, 16'd0, 16'd0, 1'b1);
    check("R12 wake", pc, 16'h0606);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_untaken();
    t_branch();
    t_overflow();
    t_exec();
    t_loop();
    t_repeat();
    t_overlap();
    t_trap_wait();
    finish_run();
  end

  initial begin
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end
endmodule